// File: doc/BRIEF.md
# Endpoint Prime and Completion Register Bank

This block is the endpoint bookkeeping core of a USB device controller. It keeps one bit per endpoint direction in five vectors: arm requests waiting for a descriptor fetch, buffers that are ready, flushes that are running, retired transfers, and setup packets that have landed. Software reaches the vectors through a plain word-addressed read/write port. The packet engine reports its progress on three event inputs: fetch done, transfer retired and setup landed.

Two command bits act as semaphores. Software sets one of them before it appends a descriptor to a live endpoint, and sets the other before it copies the eight setup bytes. The hardware knocks a bit back to zero when an event could have made that software step unsafe, so software can detect the race and retry. A single transaction flag summarises the retired and setup events as an interrupt.

Top module: `ep_prime_bank`

## Requirements
- R1: Receive endpoint n uses bit n of every vector and transmit endpoint n uses bit n+NUM_EP (n+16 by default). The word addresses are 0 command, 1 interrupt, 2 arm, 3 flush, 4 ready, 5 retired, 6 setup and 7 (reads zero). Writes to the ready vector are ignored.
- R2: Writing ones to the arm vector sets those bits. Each bit stays set until fetch_done fires for that bit. fetch_done on a bit that is not armed changes neither vector.
- R3: fetch_done on an armed bit clears the arm bit and sets the matching ready bit at the same clock edge.
- R4: A ready bit is cleared by retire on that bit, by a flush write naming it, or by bus_rst. bus_rst also clears every arm bit. A clear wins over a set in the same cycle.
- R5: A flush write clears the named arm and ready bits at once. The named flush bits then read as one for FLUSH_CYCLES cycles and clear themselves.
- R6: retire sets the matching bits of the retired vector. Writing ones clears those bits and writing zeros has no effect. A set in the same cycle as a clear wins.
- R7: setup_land[n] sets bit n of the setup vector. That vector is write-one-to-clear, and a set wins over a clear in the same cycle.
- R8: Any retire or setup_land bit sets interrupt bit 0, which drives the irq pin. Writing a one to bit 0 clears it, and a new event in the same cycle wins.
- R9: Command bit 0 (descriptor-append semaphore) is read and written by software. The hardware clears it when any retire or fetch_done bit fires while it is set, and this clear wins over a write in the same cycle. setup_land does not affect it.
- R10: Command bit 1 (setup-copy semaphore) is read and written by software. The hardware clears it when any setup_land bit fires.
- R11: A synchronous reset clears every vector, both semaphores and the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Word address for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| fetch_done | input | 2*NUM_EP | Descriptor fetch finished, per endpoint bit |
| retire | input | 2*NUM_EP | Transfer retired, per endpoint bit |
| setup_land | input | NUM_EP | Setup packet stored, per receive endpoint |
| bus_rst | input | 1 | Bus reset seen on the link |
| irq | output | 1 | Transaction interrupt flag |

## Verification
The assertions check four things on every cycle: an arm bit that meets its fetch_done becomes ready, bus_rst empties the arm and ready vectors, retire and setup events are latched into their vectors and the irq flag, and each semaphore falls after its hazard. Some behaviours appear only in the bench's scenarios: the exact length of the flush window, the write-one-to-clear rules with their set-wins ordering, the read-only ready vector, the ignored fetch_done on unarmed bits, and the reset values read back through the port.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_CMD   = 3'd0,
    A_IRQ   = 3'd1,
    A_ARM   = 3'd2,
    A_FLUSH = 3'd3,
    A_READY = 3'd4,
    A_DONE  = 3'd5,
    A_SETUP = 3'd6,
    A_NONE  = 3'd7
  } reg_sel_e;

  localparam int unsigned CMD_APPEND_BIT = 0;
  localparam int unsigned CMD_COPY_BIT   = 1;
  localparam int unsigned IRQ_TXN_BIT    = 0;
endpackage

// File: rtl/ep_arm_ready.sv
module ep_arm_ready #(
  parameter int unsigned VEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] arm_set,
  input  logic [VEC_W-1:0] fetch_done,
  input  logic [VEC_W-1:0] ready_kill,
  input  logic [VEC_W-1:0] arm_kill,
  input  logic             cancel_all,
  output logic [VEC_W-1:0] arm_q,
  output logic [VEC_W-1:0] ready_q
);
  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    logic arm_d, ready_d, fetched;
    assign fetched = arm_q[i] & fetch_done[i];

    always_comb begin
      if (cancel_all || arm_kill[i]) arm_d = 1'b0;
      else                           arm_d = (arm_q[i] & ~fetch_done[i]) | arm_set[i];
      if (cancel_all || ready_kill[i]) ready_d = 1'b0;
      else                             ready_d = ready_q[i] | fetched;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        arm_q[i]   <= 1'b0;
        ready_q[i] <= 1'b0;
      end else begin
        arm_q[i]   <= arm_d;
        ready_q[i] <= ready_d;
      end
    end
  end
endmodule

// File: rtl/ep_sticky_vec.sv
module ep_sticky_vec #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_bits) | set_bits;
  end
endmodule

// File: rtl/ep_flush_engine.sv
module ep_flush_engine #(
  parameter int unsigned VEC_W        = 32,
  parameter int unsigned FLUSH_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] start,
  output logic [VEC_W-1:0] busy_q
);
  localparam int unsigned CW = $clog2(FLUSH_CYCLES + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      left_q <= '0;
    end else if (|start) begin
      busy_q <= busy_q | start;
      left_q <= CW'(FLUSH_CYCLES);
    end else if (left_q == CW'(1)) begin
      busy_q <= '0;
      left_q <= '0;
    end else if (left_q != '0) begin
      left_q <= left_q - CW'(1);
    end
  end
endmodule

// File: rtl/ep_semaphores.sv
module ep_semaphores (
  input  logic clk,
  input  logic rst,
  input  logic cmd_wr,
  input  logic append_wbit,
  input  logic copy_wbit,
  input  logic append_hazard,
  input  logic copy_hazard,
  output logic append_q,
  output logic copy_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      append_q <= 1'b0;
      copy_q   <= 1'b0;
    end else begin
      if (append_hazard) append_q <= 1'b0;
      else if (cmd_wr)   append_q <= append_wbit;
      if (copy_hazard)   copy_q   <= 1'b0;
      else if (cmd_wr)   copy_q   <= copy_wbit;
    end
  end
endmodule

// File: rtl/ep_prime_bank.sv
module ep_prime_bank
  import ep_bank_pkg::*;
#(
  parameter int unsigned NUM_EP       = 16,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned FLUSH_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [2*NUM_EP-1:0] fetch_done,
  input  logic [2*NUM_EP-1:0] retire,
  input  logic [NUM_EP-1:0]   setup_land,
  input  logic                bus_rst,
  output logic                irq
);
  localparam int unsigned VEC_W = 2 * NUM_EP;

  reg_sel_e         sel;
  logic [VEC_W-1:0] wvec;
  logic [VEC_W-1:0] arm_go, flush_go, done_clr, setup_clr, setup_set;
  logic [VEC_W-1:0] arm_q, ready_q, flush_q, done_q, setup_q;
  logic             cmd_wr, irq_clr, irq_set;
  logic             append_q, copy_q;
  logic [0:0]       irq_q;

  assign sel  = reg_sel_e'(reg_addr);
  assign wvec = reg_wdata[VEC_W-1:0];

  // write decode: one strobe vector per target
  assign cmd_wr    = reg_wr && (sel == A_CMD);
  assign irq_clr   = reg_wr && (sel == A_IRQ) && reg_wdata[IRQ_TXN_BIT];
  assign arm_go    = (reg_wr && sel == A_ARM)   ? wvec : '0;
  assign flush_go  = (reg_wr && sel == A_FLUSH) ? wvec : '0;
  assign done_clr  = (reg_wr && sel == A_DONE)  ? wvec : '0;
  assign setup_clr = (reg_wr && sel == A_SETUP) ? wvec : '0;

  assign setup_set = {{NUM_EP{1'b0}}, setup_land};
  assign irq_set   = (|retire) || (|setup_land);

  ep_arm_ready #(.VEC_W(VEC_W)) u_arm (
    .clk        (clk),
    .rst        (rst),
    .arm_set    (arm_go),
    .fetch_done (fetch_done),
    .ready_kill (retire | flush_go),
    .arm_kill   (flush_go),
    .cancel_all (bus_rst),
    .arm_q      (arm_q),
    .ready_q    (ready_q)
  );

  ep_flush_engine #(.VEC_W(VEC_W), .FLUSH_CYCLES(FLUSH_CYCLES)) u_flush (
    .clk    (clk),
    .rst    (rst),
    .start  (flush_go),
    .busy_q (flush_q)
  );

  ep_sticky_vec #(.W(VEC_W)) u_done (
    .clk      (clk),
    .rst      (rst),
    .set_bits (retire),
    .clr_bits (done_clr),
    .q        (done_q)
  );

  ep_sticky_vec #(.W(VEC_W)) u_setup (
    .clk      (clk),
    .rst      (rst),
    .set_bits (setup_set),
    .clr_bits (setup_clr),
    .q        (setup_q)
  );

  ep_sticky_vec #(.W(1)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_bits (irq_set),
    .clr_bits (irq_clr),
    .q        (irq_q)
  );

  ep_semaphores u_sema (
    .clk           (clk),
    .rst           (rst),
    .cmd_wr        (cmd_wr),
    .append_wbit   (reg_wdata[CMD_APPEND_BIT]),
    .copy_wbit     (reg_wdata[CMD_COPY_BIT]),
    .append_hazard ((|retire) || (|fetch_done)),
    .copy_hazard   (|setup_land),
    .append_q      (append_q),
    .copy_q        (copy_q)
  );

  assign irq = irq_q[0];

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      A_CMD: begin
        reg_rdata[CMD_APPEND_BIT] = append_q;
        reg_rdata[CMD_COPY_BIT]   = copy_q;
      end
      A_IRQ:   reg_rdata[IRQ_TXN_BIT] = irq_q[0];
      A_ARM:   reg_rdata = DATA_W'(arm_q);
      A_FLUSH: reg_rdata = DATA_W'(flush_q);
      A_READY: reg_rdata = DATA_W'(ready_q);
      A_DONE:  reg_rdata = DATA_W'(done_q);
      A_SETUP: reg_rdata = DATA_W'(setup_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ep_prime_bank_chk.sv
module ep_prime_bank_chk #(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned VEC_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [VEC_W-1:0] fetch_done,
  input logic [VEC_W-1:0] retire,
  input logic [NUM_EP-1:0] setup_land,
  input logic             bus_rst,
  input logic [VEC_W-1:0] flush_go,
  input logic [VEC_W-1:0] arm_q,
  input logic [VEC_W-1:0] ready_q,
  input logic [VEC_W-1:0] done_q,
  input logic             append_q,
  input logic             copy_q,
  input logic             irq
);
  p_fetch_makes_ready_r3: assert property (@(posedge clk) disable iff (rst)
    (!bus_rst && flush_go == '0 && retire == '0)
      |=> ((ready_q & $past(arm_q & fetch_done)) == $past(arm_q & fetch_done)));

  p_busrst_cancels_r4: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> (arm_q == '0 && ready_q == '0));

  p_retire_latched_r6: assert property (@(posedge clk) disable iff (rst)
    (retire != '0) |=> ((done_q & $past(retire)) == $past(retire)));

  p_event_raises_irq_r8: assert property (@(posedge clk) disable iff (rst)
    ((retire != '0) || (setup_land != '0)) |=> irq);

  p_append_hazard_r9: assert property (@(posedge clk) disable iff (rst)
    (append_q && ((retire != '0) || (fetch_done != '0))) |=> !append_q);

  p_copy_hazard_r10: assert property (@(posedge clk) disable iff (rst)
    (copy_q && (setup_land != '0)) |=> !copy_q);
endmodule

bind ep_prime_bank ep_prime_bank_chk #(.NUM_EP(NUM_EP), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fetch_done (fetch_done),
  .retire     (retire),
  .setup_land (setup_land),
  .bus_rst    (bus_rst),
  .flush_go   (flush_go),
  .arm_q      (arm_q),
  .ready_q    (ready_q),
  .done_q     (done_q),
  .append_q   (append_q),
  .copy_q     (copy_q),
  .irq        (irq)
);

// File: tb/ep_prime_bank_tb.sv
module ep_prime_bank_tb;
  localparam int unsigned NUM_EP = 16;
  localparam int unsigned VEC_W  = 2 * NUM_EP;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [VEC_W-1:0]  fetch_done = '0;
  logic [VEC_W-1:0]  retire = '0;
  logic [NUM_EP-1:0] setup_land = '0;
  logic              bus_rst = 1'b0;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ep_prime_bank #(.NUM_EP(NUM_EP), .DATA_W(32), .FLUSH_CYCLES(4)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_done(fetch_done),
    .retire(retire), .setup_land(setup_land), .bus_rst(bus_rst), .irq(irq)
  );

  // addresses (R1): 0 cmd, 1 irq, 2 arm, 3 flush, 4 ready, 5 retired, 6 setup
  localparam logic [2:0] AC = 3'd0, AI = 3'd1, AA = 3'd2, AF = 3'd3,
                         AR = 3'd4, AD = 3'd5, AS = 3'd6;
  // ops: 0 write, 1 fetch_done, 2 retire, 3 setup_land, 4 read check
  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } row_t;
  localparam int NROW = 29;
  localparam row_t TBL [NROW] = '{
    '{3'd0, AA, 32'h0001_0004, 4'd2},  // R2 arm RX2 and TX0
    '{3'd4, AA, 32'h0001_0004, 4'd2},  // R2
    '{3'd1, AA, 32'h0000_0004, 4'd3},
    '{3'd4, AA, 32'h0001_0000, 4'd3},  // R3 arm bit falls
    '{3'd4, AR, 32'h0000_0004, 4'd3},  // R3 ready bit rises
    '{3'd1, AA, 32'h0000_0008, 4'd2},  // fetch on unarmed bit
    '{3'd4, AR, 32'h0000_0004, 4'd2},  // R2 ignored
    '{3'd4, AA, 32'h0001_0000, 4'd2},  // R2
    '{3'd0, AR, 32'hFFFF_FFFF, 4'd1},
    '{3'd4, AR, 32'h0000_0004, 4'd1},  // R1 ready is read-only
    '{3'd2, AA, 32'h0000_0004, 4'd4},
    '{3'd4, AR, 32'h0000_0000, 4'd4},  // R4 retire clears ready
    '{3'd4, AD, 32'h0000_0004, 4'd6},  // R6
    '{3'd4, AI, 32'h0000_0001, 4'd8},  // R8
    '{3'd0, AD, 32'h0000_0000, 4'd6},
    '{3'd4, AD, 32'h0000_0004, 4'd6},  // R6 writing zero has no effect
    '{3'd0, AD, 32'h0000_0004, 4'd6},
    '{3'd4, AD, 32'h0000_0000, 4'd6},  // R6 W1C
    '{3'd0, AI, 32'h0000_0001, 4'd8},
    '{3'd4, AI, 32'h0000_0000, 4'd8},  // R8 W1C
    '{3'd3, AA, 32'h0000_0001, 4'd7},
    '{3'd4, AS, 32'h0000_0001, 4'd7},  // R7
    '{3'd4, AI, 32'h0000_0001, 4'd8},  // R8 from setup
    '{3'd0, AS, 32'h0000_0001, 4'd7},
    '{3'd4, AS, 32'h0000_0000, 4'd7},  // R7 W1C
    '{3'd0, AI, 32'h0000_0001, 4'd8},
    '{3'd1, AA, 32'h0001_0000, 4'd1},
    '{3'd4, AR, 32'h0001_0000, 4'd1},  // R1 TX0 sits at bit 16
    '{3'd4, AA, 32'h0000_0000, 4'd1}   // R1
  };

  task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d,
                      input logic [31:0] fd, input logic [31:0] rt,
                      input logic [15:0] sl, input logic br);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    fetch_done = fd; retire = rt; setup_land = sl; bus_rst = br;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; fetch_done = '0; retire = '0;
    setup_land = '0; bus_rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1'b1, a, d, '0, '0, '0, 1'b0);
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    for (int a = 0; a < 8; a++) chk(3'(a), 32'h0, "R11 reset value");
    chk_irq(1'b0, "R11 reset irq");

    for (int i = 0; i < NROW; i++) begin
      case (TBL[i].op)
        3'd0: wr(TBL[i].addr, TBL[i].data);
        3'd1: step(1'b0, 3'd7, '0, TBL[i].data, '0, '0, 1'b0);
        3'd2: step(1'b0, 3'd7, '0, '0, TBL[i].data, '0, 1'b0);
        3'd3: step(1'b0, 3'd7, '0, '0, '0, TBL[i].data[15:0], 1'b0);
        default: chk(TBL[i].addr, TBL[i].data, $sformatf("R%0d row %0d", TBL[i].req, i));
      endcase
    end

    // R5 flush window
    wr(AA, 32'h20);
    step(1'b0, 3'd7, '0, 32'h20, '0, '0, 1'b0);
    wr(AA, 32'h40);
    wr(AF, 32'h60);
    chk(AR, 32'h0001_0000, "R5 flush clears ready");
    chk(AA, 32'h0, "R5 flush clears arm");
    chk(AF, 32'h60, "R5 flush busy");
    repeat (3) @(negedge clk);
    chk(AF, 32'h60, "R5 flush still busy");
    @(negedge clk);
    chk(AF, 32'h0, "R5 flush self-clear");

    // R4 bus reset
    wr(AA, 32'h80);
    step(1'b0, 3'd7, '0, 32'h80, '0, '0, 1'b0);
    wr(AA, 32'h100);
    chk(AR, 32'h0001_0080, "R4 ready before bus reset");
    step(1'b0, 3'd7, '0, '0, '0, '0, 1'b1);
    chk(AA, 32'h0, "R4 bus reset clears arm");
    chk(AR, 32'h0, "R4 bus reset clears ready");

    // R9 descriptor-append semaphore
    wr(AC, 32'h1);
    chk(AC, 32'h1, "R9 software set");
    step(1'b0, 3'd7, '0, '0, '0, 16'h2, 1'b0);
    chk(AC, 32'h1, "R9 setup does not trip");
    step(1'b0, 3'd7, '0, '0, 32'h2, '0, 1'b0);
    chk(AC, 32'h0, "R9 retire trips");
    wr(AC, 32'h1);
    step(1'b0, 3'd7, '0, 32'h1, '0, '0, 1'b0);
    chk(AC, 32'h0, "R9 fetch trips");

    // R10 setup-copy semaphore
    wr(AC, 32'h3);
    step(1'b0, 3'd7, '0, '0, '0, 16'h4, 1'b0);
    chk(AC, 32'h1, "R10 setup trips");
    wr(AC, 32'h0);
    chk(AC, 32'h0, "R10 software clear");

    // R6 set wins over clear
    wr(AD, 32'hFFFF_FFFF);
    chk(AD, 32'h0, "R6 clear all");
    step(1'b1, AD, 32'h8, '0, 32'h8, '0, 1'b0);
    chk(AD, 32'h8, "R6 set wins");
    chk_irq(1'b1, "R8 irq pin");
    step(1'b1, AI, 32'h1, '0, '0, 16'h1, 1'b0);
    chk_irq(1'b1, "R8 event beats clear");

    // R11 reset mid-run
    wr(AA, 32'h3);
    wr(AC, 32'h3);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk(AA, 32'h0, "R11 arm after reset");
    chk(AC, 32'h0, "R11 cmd after reset");
    chk(AD, 32'h0, "R11 retired after reset");
    chk(AS, 32'h0, "R11 setup after reset");
    chk_irq(1'b0, "R11 irq after reset");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule